// File: doc/BRIEF.md
# Discharge-Time Measurement Counter

This block turns a quiescent-current measurement into a number of clock cycles. The circuit under test is cut off from its supply, and its supply rail then sinks slowly through the circuit's own leakage. An analog comparator reports whether the rail is still above a reference. The block counts the cycles that the rail needs to fall below that reference. A small count means a large current and a large count means a small current.

A test sequence arms the block once with a start strobe. For every test vector, the supply switch-control input goes high for one measurement window. The rising edge of that input clears the counter. It also starts an optional programmable settling delay, which is loaded from a configuration input at that edge. When the delay has run out, the counter advances on every cycle in which the comparator bit is high. The first cycle in which the comparator reports the rail below the reference ends the measurement. The count is then captured into the result register and a one-cycle valid pulse is raised.

If the comparator never falls, the counter stops at its all-ones value. The block then raises the overflow flag together with the valid pulse, so a stuck switch or a stuck comparator cannot hang the measurement. A width parameter sets the counter size. A second parameter removes the delay path entirely when a design does not need settling time.

Top module: `dtm_counter`

## Requirements
- R1: While reset is asserted and after it is released, `result_o` is zero and `valid_o` and `overflow_o` are low.
- R2: Before the first `start_i` strobe after reset, rising edges of `sw_open_i` start no measurement: `valid_o` stays low and `result_o` keeps its value.
- R3: Each rising edge of `sw_open_i` clears the counter to zero. With a delay of zero, the first cycle that may be counted is the clock edge after the edge that sampled the rise.
- R4: With `delay_i` = D sampled at the rising edge, the D clock edges that follow are not counted. The first cycle that may be counted is edge D+1 after the rise.
- R5: Inside the counting window, the counter advances by one on each edge at which `cmp_above_i` is high and holds otherwise. If the comparator is high from the rising edge and falls before the Tth edge after it (edges numbered from 0), the result is max(0, T-1-D).
- R6: At the first counting-window edge with `cmp_above_i` low, the count is written to `result_o`, `overflow_o` is cleared, and `valid_o` is high for exactly one cycle. This happens D+1+count edges after the rise.
- R7: If the count has reached all-ones and the comparator is still high, `result_o` becomes all-ones, `overflow_o` is set and `valid_o` pulses. This happens D+1+(2^CNT_W-1) edges after the rise.
- R8: After a measurement ends, a comparator return to high is ignored until the next rising edge of `sw_open_i`: `valid_o` stays low and `result_o` is unchanged.
- R9: If `sw_open_i` falls during the delay or the counting window, the measurement is abandoned: no valid pulse is raised and `result_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Arming strobe for the test sequence |
| sw_open_i | input | 1 | High while the supply switch is open (one window per vector) |
| cmp_above_i | input | 1 | Comparator bit, high while the rail is above the reference |
| delay_i | input | DLY_W | Settling delay in cycles, sampled at the rising edge of `sw_open_i` |
| result_o | output | CNT_W | Captured discharge count |
| valid_o | output | 1 | One-cycle pulse when a new result is written |
| overflow_o | output | 1 | Set when the last measurement hit the all-ones limit |

## Verification
The bench sweeps every delay value of a 3-bit configuration against comparator fall times that run from zero to beyond the 4-bit counter limit. For each case it checks the result, the overflow flag and the exact latency of the valid pulse. A design that counted during the delay, or that missed the first window cycle, would be off by one along a whole diagonal of the sweep. A design that wrapped instead of saturating would report small counts with no overflow when the fall time is long. The bench also brings the comparator back high after every stop and drops the switch in the middle of a window. A block that resumed counting or captured a partial count would then produce a stray valid pulse or a changed result.

// File: rtl/dtm_pkg.sv
`timescale 1ns/1ps
package dtm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2,
      ST_HELD = 2'd3
   } dtm_state_e;
endpackage

// File: rtl/dtm_rise.sv
`timescale 1ns/1ps
module dtm_rise (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise
);
   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign rise = level & ~level_q;
endmodule

// File: rtl/dtm_delay.sv
`timescale 1ns/1ps
module dtm_delay #(
   parameter int unsigned DLY_W     = 8,
   parameter bit          USE_DELAY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] cfg,
   input  logic             tick,
   output logic             cfg_zero,
   output logic             last
);
   generate
      if (USE_DELAY) begin : g_delay
         logic [DLY_W-1:0] rem_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     rem_q <= '0;
            else if (load)                  rem_q <= cfg;
            else if (tick && rem_q != '0)   rem_q <= rem_q - 1'b1;
         end

         assign cfg_zero = (cfg == '0);
         assign last     = (rem_q == DLY_W'(1));
      end else begin : g_nodelay
         logic unused_sink;
         assign unused_sink = ^{cfg, load, tick, clk, rst_n};
         assign cfg_zero    = 1'b1;
         assign last        = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/dtm_gcount.sv
`timescale 1ns/1ps
module dtm_gcount #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] value,
   output logic         at_max
);
   localparam logic [W-1:0] FULL = {W{1'b1}};

   assign at_max = (value == FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               value <= '0;
      else if (clr)             value <= '0;
      else if (inc && !at_max)  value <= value + 1'b1;
   end
endmodule

// File: rtl/dtm_counter.sv
`timescale 1ns/1ps
module dtm_counter
   import dtm_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned DLY_W     = 8,
   parameter bit          USE_DELAY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             sw_open_i,
   input  logic             cmp_above_i,
   input  logic [DLY_W-1:0] delay_i,
   output logic [CNT_W-1:0] result_o,
   output logic             valid_o,
   output logic             overflow_o
);
   localparam logic [CNT_W-1:0] RES_FULL = {CNT_W{1'b1}};

   initial begin
      if (CNT_W < 2)  $error("dtm_counter: CNT_W must be at least 2");
      if (DLY_W < 1)  $error("dtm_counter: DLY_W must be at least 1");
   end

   dtm_state_e       st_q, st_d;
   logic             armed_q;
   logic             sw_rise, launch;
   logic             cnt_clr, cnt_inc, cnt_at_max;
   logic [CNT_W-1:0] cnt_val;
   logic             dly_load, dly_tick, dly_zero, dly_last;
   logic             cap, cap_ovf;

   dtm_rise u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .level (sw_open_i),
      .rise  (sw_rise)
   );

   dtm_delay #(.DLY_W(DLY_W), .USE_DELAY(USE_DELAY)) u_delay (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dly_load),
      .cfg      (delay_i),
      .tick     (dly_tick),
      .cfg_zero (dly_zero),
      .last     (dly_last)
   );

   dtm_gcount #(.W(CNT_W)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cnt_clr),
      .inc    (cnt_inc),
      .value  (cnt_val),
      .at_max (cnt_at_max)
   );

   assign launch = sw_rise & armed_q;

   always_comb begin
      st_d     = st_q;
      cnt_clr  = 1'b0;
      cnt_inc  = 1'b0;
      dly_load = 1'b0;
      dly_tick = 1'b0;
      cap      = 1'b0;
      cap_ovf  = 1'b0;
      if (launch) begin
         cnt_clr  = 1'b1;
         dly_load = 1'b1;
         st_d     = dly_zero ? ST_RUN : ST_WAIT;
      end else begin
         case (st_q)
            ST_WAIT: begin
               if (!sw_open_i) st_d = ST_IDLE;
               else begin
                  dly_tick = 1'b1;
                  if (dly_last) st_d = ST_RUN;
               end
            end
            ST_RUN: begin
               if (!sw_open_i) st_d = ST_IDLE;
               else if (!cmp_above_i) begin
                  cap  = 1'b1;
                  st_d = ST_HELD;
               end else if (cnt_at_max) begin
                  cap     = 1'b1;
                  cap_ovf = 1'b1;
                  st_d    = ST_HELD;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            default: st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         armed_q    <= 1'b0;
         result_o   <= '0;
         valid_o    <= 1'b0;
         overflow_o <= 1'b0;
      end else begin
         st_q    <= st_d;
         armed_q <= armed_q | start_i;
         valid_o <= cap;
         if (cap) begin
            result_o   <= cap_ovf ? RES_FULL : cnt_val;
            overflow_o <= cap_ovf;
         end
      end
   end
endmodule

// File: rtl/dtm_counter_chk.sv
`timescale 1ns/1ps
module dtm_counter_chk
   import dtm_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_open_i,
   input logic             cmp_above_i,
   input dtm_state_e       st_q,
   input logic             launch,
   input logic             armed_q,
   input logic [CNT_W-1:0] cnt_val,
   input logic             cnt_at_max,
   input logic [CNT_W-1:0] result_o,
   input logic             valid_o,
   input logic             overflow_o
);
   // R1 / R2: nothing is reported before the block is armed
   a_r2_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> !valid_o);

   // R3: a switch-open edge leaves the counter at zero
   a_r3_clear_on_open: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (cnt_val == '0));

   // R5: outside the counting window the counter does not move
   a_r5_no_count_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_RUN && !launch) |=> $stable(cnt_val));

   // R6: comparator fall captures the count with a clean flag
   a_r6_stop_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && !launch && sw_open_i && !cmp_above_i)
      |=> (valid_o && !overflow_o && result_o == $past(cnt_val)));

   // R6: valid is a single-cycle pulse
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R7: a full counter with the comparator still high saturates and flags
   a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && !launch && sw_open_i && cmp_above_i && cnt_at_max)
      |=> (valid_o && overflow_o && (&result_o)));

   // R7: the flag never accompanies a partial count
   a_r7_flag_means_full: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |-> (&result_o));

   // R8 / R9: the result only changes together with a valid pulse
   a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_o) |-> valid_o);
endmodule

bind dtm_counter dtm_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sw_open_i   (sw_open_i),
   .cmp_above_i (cmp_above_i),
   .st_q        (st_q),
   .launch      (launch),
   .armed_q     (armed_q),
   .cnt_val     (cnt_val),
   .cnt_at_max  (cnt_at_max),
   .result_o    (result_o),
   .valid_o     (valid_o),
   .overflow_o  (overflow_o)
);

// File: tb/dtm_counter_test.sv
`timescale 1ns/1ps
module dtm_counter_test;
   localparam int CW   = 4;
   localparam int DW   = 3;
   localparam int FULL = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          sw_open_i = 1'b0;
   logic          cmp_above_i = 1'b0;
   logic [DW-1:0] delay_i = '0;
   logic [CW-1:0] result_o;
   logic          valid_o;
   logic          overflow_o;

   int  nvec = 0;
   int  nfail = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   dtm_counter #(.CNT_W(CW), .DLY_W(DW), .USE_DELAY(1'b1)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .sw_open_i   (sw_open_i),
      .cmp_above_i (cmp_above_i),
      .delay_i     (delay_i),
      .result_o    (result_o),
      .valid_o     (valid_o),
      .overflow_o  (overflow_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // one measurement: delay d, comparator high for edges 0..t-1 after the rise
   task automatic run_vec(input int d, input int t);
      int  hi, exp_res, exp_lat, lat, held;
      bit  exp_ovf, got, stray;
      hi      = (t > d + 1) ? (t - 1 - d) : 0;
      exp_ovf = (hi > FULL);
      exp_res = exp_ovf ? FULL : hi;
      exp_lat = d + 1 + ((hi < FULL) ? hi : FULL);
      got = 1'b0;
      lat = -1;
      delay_i     = DW'(d);
      sw_open_i   = 1'b1;
      cmp_above_i = (t > 0);
      for (int i = 0; i < 64; i++) begin
         step();
         if (valid_o) begin
            got = 1'b1;
            lat = i;
            break;
         end
         cmp_above_i = (i + 1 < t);
      end
      chk(got, "R6 valid pulse seen", int'(got), 1);
      chk(lat == exp_lat, "R4/R6/R7 valid latency", lat, exp_lat);
      chk(int'(result_o) == exp_res, "R5/R7 result", int'(result_o), exp_res);
      chk(overflow_o == exp_ovf, "R7 overflow flag", int'(overflow_o), int'(exp_ovf));
      // R8: comparator returns high after the stop
      held = int'(result_o);
      stray = 1'b0;
      cmp_above_i = 1'b1;
      for (int j = 0; j < 4; j++) begin
         step();
         if (valid_o) stray = 1'b1;
      end
      chk(!stray, "R8 no valid after glitch", int'(stray), 0);
      chk(int'(result_o) == held, "R8 result held after glitch", int'(result_o), held);
      sw_open_i   = 1'b0;
      cmp_above_i = 1'b0;
      step();
      step();
   endtask

   initial begin
      int  prev;
      bit  seen;
      @(negedge clk);
      step();
      chk(result_o == '0 && !valid_o && !overflow_o, "R1 in reset",
          int'(result_o) + int'(valid_o) + int'(overflow_o), 0);
      rst_n = 1'b1;
      step();
      chk(result_o == '0 && !valid_o && !overflow_o, "R1 after reset",
          int'(result_o) + int'(valid_o) + int'(overflow_o), 0);

      // R2: switch activity before arming
      seen = 1'b0;
      sw_open_i   = 1'b1;
      cmp_above_i = 1'b1;
      for (int i = 0; i < 6; i++) begin
         step();
         if (valid_o) seen = 1'b1;
         if (i == 3) cmp_above_i = 1'b0;
      end
      sw_open_i = 1'b0;
      step();
      if (valid_o) seen = 1'b1;
      chk(!seen, "R2 unarmed no valid", int'(seen), 0);
      chk(result_o == '0, "R2 unarmed result", int'(result_o), 0);

      start_i = 1'b1;
      step();
      start_i = 1'b0;
      step();

      // R3..R8: sweep every delay against comparator fall times
      for (int d = 0; d < (1 << DW); d++) begin
         for (int t = 0; t <= d + FULL + 4; t++) begin
            run_vec(d, t);
         end
      end

      // R3: small result right after a saturated one
      run_vec(0, 40);
      run_vec(0, 3);

      // R9: switch drops inside the delay, then inside the counting window
      for (int k = 0; k < 2; k++) begin
         prev = int'(result_o);
         seen = 1'b0;
         delay_i     = DW'(k == 0 ? 5 : 1);
         sw_open_i   = 1'b1;
         cmp_above_i = 1'b1;
         for (int i = 0; i < 4; i++) begin
            step();
            if (valid_o) seen = 1'b1;
         end
         sw_open_i = 1'b0;
         for (int i = 0; i < 6; i++) begin
            step();
            if (valid_o) seen = 1'b1;
            if (i == 2) cmp_above_i = 1'b0;
         end
         chk(!seen, "R9 abort no valid", int'(seen), 0);
         chk(int'(result_o) == prev, "R9 abort result held", int'(result_o), prev);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nvec++;
         nfail++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end
endmodule